// File: doc/BRIEF.md
# Cipher Accelerator Host Register Front End

This block sits between a 32-bit register bus and a symmetric cipher engine. Software writes plaintext words into a write-only input queue and reads results from a read-only output queue. The block also holds the cipher key, a key length, an algorithm and mode selection, and a byte count for the job. Each port is defined for access in the wrong direction, so a stray access never corrupts state.

The byte count is checked for legality when it is written, against the algorithm and mode in force. Misuse is recorded in sticky error flags: an illegal byte count, a push into a full input queue, and a pop from an empty output queue. Each flag has its own mask bit, and together they drive one interrupt line. In place of the cipher datapath, a pass-through stage moves one word per cycle from the input queue to the output queue. It uses valid/ready back-pressure and moves a word only when the input queue holds data and the output queue has room. The register bus itself has no back-pressure: software polls the queue levels, and a push that does not fit is dropped.

Bus accesses are single-cycle strobes. Read data is registered and appears on `rdata_o` after the clock edge that sampled `rd_en_i`, and holds until the next read.

Top module: `cipher_host_regs`

## Requirements
- R1: After reset both queue levels, the error flags, the mask bits, the key length and the mode are zero, and `irq_o` is low.
- R2: Each write to offset 0x20 is accepted into the input queue unless that queue is full. Each read of offset 0x24 that finds the output queue non-empty returns the oldest word held. Words leave in the order they were written.
- R3: A read of offset 0x20 returns zero and leaves both queue levels unchanged.
- R4: A write to offset 0x24 has no effect: the queue levels and the queued words are unchanged.
- R5: A write to offset 0x20 while the input queue holds 16 words is dropped, leaving the queue contents unchanged, and sets error bit 1 (input overflow).
- R6: A read of offset 0x24 while the output queue is empty returns zero, leaves the level at zero, and sets error bit 2 (output underflow).
- R7: A read of the status register at offset 0x04 returns the input queue level in bits [4:0] and the output queue level in bits [12:8], each counted in 32-bit words.
- R8: A write to offset 0x1C stores the byte count in bits [23:0], readable at the same offset, and checks it against the mode register at offset 0x00. The mode register holds the algorithm in bits [1:0] (0 single DES, 1 triple DES, 2 AES, 3 treated like AES) and the counter-mode flag in bit 2. With the counter flag set, any multiple of 8 is legal. Otherwise DES and triple DES need a multiple of 8, and AES needs a multiple of 16. An illegal count sets error bit 0.
- R9: The error flags at offset 0x08 are sticky and are cleared only by writing 1 to the bit.
- R10: `irq_o` is high exactly when some error bit is set and the mask bit in the same position of the mask register at offset 0x0C is zero.
- R11: Six write-only key words sit at offsets 0x28 to 0x3C, and a read of any of them returns zero. `key_o` carries key word n (n = 0..5, the first four key bytes in word 0) in bits [32n+31:32n] only when n is below the word count held in the key length register at offset 0x10. Otherwise those bits are zero. Key words may be written before the length is set.
- R12: The pass-through stage moves one word per cycle whenever the input queue is non-empty and the output queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register accessed |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, unmasked errors ORed |
| key_o | output | 192 | Key words presented to the cipher engine, trimmed to the key length |

## Verification
The bench drives the queues to their edges. It fills both queues to 32 words in total and then pushes once more, which must be dropped. A design with a wrong full test would either store the extra word or lose an earlier one, and the scoreboard then sees a wrong word or a wrong count. It pops an empty output queue and reads the input queue address: a design that returned stale data or moved a level would fail the zero-data and level checks. It walks the byte-count rule across all three algorithm families, with and without counter mode, where a design testing the wrong number of low bits flags a legal count or misses an illegal one. It also checks that masked errors stay quiet on `irq_o`, and that key words past the programmed length read as zero on `key_o`.

// File: rtl/cipher_host_pkg.sv
package cipher_host_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // register offsets; 0x1C, 0x20 and 0x24 are fixed by software convention
  localparam logic [ADDR_W-1:0] A_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'h04;
  localparam logic [ADDR_W-1:0] A_ERR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_KLEN  = 8'h10;
  localparam logic [ADDR_W-1:0] A_DSIZE = 8'h1C;
  localparam logic [ADDR_W-1:0] A_IN    = 8'h20;
  localparam logic [ADDR_W-1:0] A_OUT   = 8'h24;
  localparam logic [ADDR_W-1:0] A_KEY0  = 8'h28;

  localparam int unsigned N_ERR    = 3;
  localparam int unsigned ERR_SIZE = 0;
  localparam int unsigned ERR_OVF  = 1;
  localparam int unsigned ERR_UDF  = 2;
  localparam int unsigned STAT_OUT_LSB = 8;

  typedef enum logic [1:0] {
    ALG_DES  = 2'd0,
    ALG_TDES = 2'd1,
    ALG_AES  = 2'd2,
    ALG_RSV  = 2'd3
  } alg_e;

  typedef struct packed {
    logic ctr;
    alg_e alg;
  } mode_t;
endpackage

// File: rtl/chr_fifo.sv
module chr_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [WIDTH-1:0] pop_data,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign push_ready = (level != LVL_W'(DEPTH));
  assign pop_valid  = (level != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign pop_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/chr_stub_core.sv
// Stand-in for the cipher datapath: forwards words with valid/ready.
module chr_stub_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [WIDTH-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [WIDTH-1:0] m_data
);
  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign m_data  = s_data;
endmodule

// File: rtl/chr_size_check.sv
module chr_size_check import cipher_host_pkg::*; #(
  parameter int unsigned SIZE_W = 24
) (
  input  mode_t             mode_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              legal_o
);
  logic mult8, mult16;
  assign mult8  = (size_i[2:0] == 3'b000);
  assign mult16 = mult8 && !size_i[3];

  always_comb begin
    if (mode_i.ctr) legal_o = mult8;
    else begin
      case (mode_i.alg)
        ALG_DES, ALG_TDES: legal_o = mult8;
        default:           legal_o = mult16;
      endcase
    end
  end
endmodule

// File: rtl/chr_key_bank.sv
module chr_key_bank #(
  parameter int unsigned WORDS  = 6,
  parameter int unsigned WIDTH  = 32,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned LEN_W = $clog2(WORDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [WIDTH-1:0]       wdata_i,
  input  logic [LEN_W-1:0]       len_i,
  output logic [WORDS*WIDTH-1:0] key_o
);
  logic [WIDTH-1:0] key_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[g] <= '0;
      else if (wr_en_i && idx_i == IDX_W'(g)) key_q[g] <= wdata_i;
    end
    assign key_o[g*WIDTH +: WIDTH] = (LEN_W'(g) < len_i) ? key_q[g] : '0;
  end
endmodule

// File: rtl/cipher_host_regs.sv
module cipher_host_regs import cipher_host_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned KEY_WORDS  = 6,
  parameter int unsigned DSIZE_W    = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        irq_o,
  output logic [KEY_WORDS*DATA_W-1:0] key_o
);
  localparam int unsigned LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned KLEN_W = $clog2(KEY_WORDS + 1);
  localparam int unsigned KIDX_W = $clog2(KEY_WORDS);

  mode_t              mode_q;
  logic [N_ERR-1:0]   err_q, mask_q, err_set, err_clr;
  logic [KLEN_W-1:0]  klen_q;
  logic [DSIZE_W-1:0] dsize_q;
  logic [DATA_W-1:0]  stat_word;
  logic [LVL_W-1:0]   in_lvl, out_lvl;
  logic               in_wr, in_ready, in_pv, in_pr;
  logic               out_rd, out_valid, out_ready, mid_v;
  logic [DATA_W-1:0]  in_pd, mid_d, out_data;
  logic               size_ok, key_hit;
  logic [ADDR_W-1:0]  key_off;

  assign in_wr  = wr_en_i && (addr_i == A_IN);
  assign out_rd = rd_en_i && (addr_i == A_OUT);

  chr_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_q (
    .clk, .rst_n,
    .push_valid(in_wr), .push_ready(in_ready), .push_data(wdata_i),
    .pop_valid(in_pv), .pop_ready(in_pr), .pop_data(in_pd),
    .level(in_lvl)
  );

  chr_stub_core #(.WIDTH(DATA_W)) u_core (
    .s_valid(in_pv), .s_ready(in_pr), .s_data(in_pd),
    .m_valid(mid_v), .m_ready(out_ready), .m_data(mid_d)
  );

  chr_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_q (
    .clk, .rst_n,
    .push_valid(mid_v), .push_ready(out_ready), .push_data(mid_d),
    .pop_valid(out_valid), .pop_ready(out_rd), .pop_data(out_data),
    .level(out_lvl)
  );

  chr_size_check #(.SIZE_W(DSIZE_W)) u_size (
    .mode_i(mode_q), .size_i(wdata_i[DSIZE_W-1:0]), .legal_o(size_ok)
  );

  assign key_off = addr_i - A_KEY0;
  assign key_hit = wr_en_i && (addr_i >= A_KEY0) && (addr_i[1:0] == 2'b00)
                && (key_off < ADDR_W'(KEY_WORDS * 4));

  chr_key_bank #(.WORDS(KEY_WORDS), .WIDTH(DATA_W)) u_keys (
    .clk, .rst_n,
    .wr_en_i(key_hit), .idx_i(key_off[KIDX_W+1:2]), .wdata_i(wdata_i),
    .len_i(klen_q), .key_o(key_o)
  );

  always_comb begin
    err_set           = '0;
    err_set[ERR_SIZE] = wr_en_i && (addr_i == A_DSIZE) && !size_ok;
    err_set[ERR_OVF]  = in_wr && !in_ready;
    err_set[ERR_UDF]  = out_rd && !out_valid;
    err_clr = (wr_en_i && addr_i == A_ERR) ? wdata_i[N_ERR-1:0] : '0;
  end

  always_comb begin
    stat_word = '0;
    stat_word[LVL_W-1:0]             = in_lvl;
    stat_word[STAT_OUT_LSB +: LVL_W] = out_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mask_q  <= '0;
      err_q   <= '0;
      klen_q  <= '0;
      dsize_q <= '0;
      rdata_o <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set;
      if (wr_en_i) begin
        case (addr_i)
          A_MODE: begin
            mode_q.alg <= alg_e'(wdata_i[1:0]);
            mode_q.ctr <= wdata_i[2];
          end
          A_MASK:  mask_q  <= wdata_i[N_ERR-1:0];
          A_KLEN:  klen_q  <= wdata_i[KLEN_W-1:0];
          A_DSIZE: dsize_q <= wdata_i[DSIZE_W-1:0];
          default: ;
        endcase
      end
      if (rd_en_i) begin
        case (addr_i)
          A_MODE:  rdata_o <= DATA_W'(mode_q);
          A_STAT:  rdata_o <= stat_word;
          A_ERR:   rdata_o <= DATA_W'(err_q);
          A_MASK:  rdata_o <= DATA_W'(mask_q);
          A_KLEN:  rdata_o <= DATA_W'(klen_q);
          A_DSIZE: rdata_o <= DATA_W'(dsize_q);
          A_OUT:   rdata_o <= out_valid ? out_data : '0;
          default: rdata_o <= '0;
        endcase
      end
    end
  end

  assign irq_o = |(err_q & ~mask_q);
endmodule

// File: rtl/cipher_host_regs_chk.sv
module cipher_host_regs_chk import cipher_host_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [LVL_W-1:0]  in_lvl,
  input logic [LVL_W-1:0]  out_lvl,
  input logic [N_ERR-1:0]  err_q
);
  logic [N_ERR-1:0] clr_req, keep;
  assign clr_req = (wr_en_i && addr_i == A_ERR) ? wdata_i[N_ERR-1:0] : '0;
  assign keep    = err_q & ~clr_req;

  // R7
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lvl <= LVL_W'(DEPTH)) && (out_lvl <= LVL_W'(DEPTH)));

  // R5
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_IN && in_lvl == LVL_W'(DEPTH)) |=> err_q[ERR_OVF]);

  // R6
  udf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_OUT && out_lvl == '0) |=> (err_q[ERR_UDF] && rdata_o == '0));

  // R3
  in_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_IN) |=> (rdata_o == '0));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != '0) |=> ((err_q & $past(keep)) == $past(keep)));
endmodule

bind cipher_host_regs cipher_host_regs_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .in_lvl(in_lvl), .out_lvl(out_lvl), .err_q(err_q)
);

// File: tb/cipher_host_regs_tb_top.sv
module cipher_host_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;
  logic [191:0] key;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  cipher_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .key_o(key)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // driver: push accepted words into the scoreboard (both queues hold 32 words in total)
  task automatic push_word(input logic [31:0] d);
    if (exp_q.size() < 32) exp_q.push_back(d);
    bus_wr(8'h20, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares every output-queue read against the scoreboard (R2, R6)
  always @(posedge clk) begin
    logic hit;
    logic [31:0] exp;
    hit = rd_en && addr == 8'h24 && rst_n;
    #2;
    if (hit) begin
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
      check("R2/R6 output word", rdata, exp);
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(2); rst_n = 1'b1; idle(1);
    // R1 reset state
    bus_rd(8'h04, d); check("R1 status", d, 32'h0);
    bus_rd(8'h08, d); check("R1 errors", d, 32'h0);
    bus_rd(8'h0C, d); check("R1 mask", d, 32'h0);
    bus_rd(8'h00, d); check("R1 mode", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 key", key[31:0], 32'h0);

    // R12 / R7 pass-through and levels
    push_word(32'h1111_0001); push_word(32'h1111_0002); push_word(32'h1111_0003);
    idle(3);
    bus_rd(8'h04, d); check("R7 R12 levels after 3 pushes", d, 32'h0000_0300);
    // R3 read of input port
    bus_rd(8'h20, d); check("R3 input port reads zero", d, 32'h0);
    bus_rd(8'h04, d); check("R3 levels unchanged", d, 32'h0000_0300);
    // R4 write to output port ignored
    bus_wr(8'h24, 32'hDEAD_BEEF);
    bus_rd(8'h04, d); check("R4 levels unchanged", d, 32'h0000_0300);
    for (int i = 0; i < 3; i++) bus_rd(8'h24, d);
    // R6 underflow
    bus_rd(8'h24, d);
    bus_rd(8'h08, d); check("R6 underflow flag", d, 32'h4);
    bus_rd(8'h04, d); check("R6 level stays zero", d, 32'h0);
    check("R10 irq on unmasked error", {31'b0, irq}, 32'h1);
    // R9 sticky, write-1-to-clear
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h08, d); check("R9 other bit kept", d, 32'h4);
    bus_wr(8'h08, 32'h4);
    bus_rd(8'h08, d); check("R9 cleared", d, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    // R10 masking
    bus_wr(8'h0C, 32'h4);
    bus_rd(8'h24, d);
    bus_rd(8'h08, d); check("R10 masked flag still set", d, 32'h4);
    check("R10 masked irq low", {31'b0, irq}, 32'h0);
    bus_wr(8'h0C, 32'h0);
    check("R10 unmask raises irq", {31'b0, irq}, 32'h1);
    bus_wr(8'h08, 32'h7);

    // R5 overflow: 33 pushes, last one dropped
    for (int i = 0; i < 33; i++) push_word(32'hA500_0000 + i);
    idle(3);
    bus_rd(8'h04, d); check("R5 R7 both queues full", d, 32'h0000_1010);
    bus_rd(8'h08, d); check("R5 overflow flag", d, 32'h2);
    for (int i = 0; i < 32; i++) bus_rd(8'h24, d);
    idle(2);
    bus_rd(8'h04, d); check("R5 drained", d, 32'h0);
    check("R5 scoreboard empty", exp_q.size(), 32'h0);
    bus_wr(8'h08, 32'h7);

    // R8 byte-count legality
    bus_wr(8'h00, 32'h0); bus_wr(8'h1C, 32'd24);
    bus_rd(8'h08, d); check("R8 DES 24 legal", d, 32'h0);
    bus_rd(8'h1C, d); check("R8 count readback", d, 32'd24);
    bus_wr(8'h1C, 32'd20);
    bus_rd(8'h08, d); check("R8 DES 20 illegal", d, 32'h1);
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h00, 32'h1); bus_wr(8'h1C, 32'd12);
    bus_rd(8'h08, d); check("R8 TDES 12 illegal", d, 32'h1);
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h00, 32'h2); bus_wr(8'h1C, 32'd24);
    bus_rd(8'h08, d); check("R8 AES 24 illegal", d, 32'h1);
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h1C, 32'd32);
    bus_rd(8'h08, d); check("R8 AES 32 legal", d, 32'h0);
    bus_wr(8'h00, 32'h6); bus_wr(8'h1C, 32'd24);
    bus_rd(8'h08, d); check("R8 AES counter 24 legal", d, 32'h0);
    bus_wr(8'h1C, 32'd28);
    bus_rd(8'h08, d); check("R8 AES counter 28 illegal", d, 32'h1);
    bus_wr(8'h08, 32'h1);

    // R11 key bank
    for (int i = 0; i < 6; i++) bus_wr(8'h28 + 8'(4 * i), 32'hC0DE_0000 + i);
    check("R11 zero length hides key", key[31:0], 32'h0);
    bus_rd(8'h30, d); check("R11 key reads zero", d, 32'h0);
    bus_wr(8'h10, 32'd4);
    check("R11 word0", key[31:0], 32'hC0DE_0000);
    check("R11 word3", key[127:96], 32'hC0DE_0003);
    check("R11 word4 trimmed", key[159:128], 32'h0);
    check("R11 word5 trimmed", key[191:160], 32'h0);
    bus_wr(8'h10, 32'd6);
    check("R11 word5 present", key[191:160], 32'hC0DE_0005);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule